// File: doc/BRIEF.md
# Clock Synthesizer Setting Selector

This block chooses which frequency setting drives a downstream clock synthesizer and presents that setting as registered control values. Four sources can apply: the five strap bits captured once after power-up, a five-bit software ratio code, a programmable N/M pair, and a recovery N/M pair. The recovery pair is used once a watchdog has forced the system into recovery mode. The ratio code picks the bus ratios and one of four PLL gear constants. In programmable mode the synthesizer output follows G*(N+3)/(M+3), where N is 8 bits wide and M is 7 bits wide.

The block is placed between the configuration registers and the synthesizer. It sees every register as a live level. It produces the selected ratio code, the gear index, the N and M values and a mode code. It also issues a one-cycle load pulse on every clock in which the effective setting moves, so the synthesizer knows when to relock. While recovery mode is active, the software select code, the override bit, the programmable enable and the normal N/M pair cannot move the output.

Top module: `clk_src_select`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs after that edge are: `code_o`=0, `gear_o`=0 (G1), `n_o`=0, `m_o`=0, `mode_o`=2'b00, `load_o`=0.
- R2: The strap copy takes `strap_i` on the STRAP_DELAY-th rising edge at which `rst_n` is high, and holds 0 before that. Later changes of `strap_i` have no effect until the next reset.
- R3: Outside recovery, with `prog_en_i`=0: `mode_o`=2'b00 (table mode), `n_o`=`m_o`=0, and `code_o` is `sw_code_i` when `override_i`=1 and the strap copy when `override_i`=0. In this mode the normal N/M inputs have no effect.
- R4: Outside recovery, with `prog_en_i`=1: `mode_o`=2'b01, `n_o`/`m_o` follow `norm_n_i`/`norm_m_i`, and `code_o` follows the same override rule as R3.
- R5: `gear_o` encodes G1..G4 as 0..3. Codes 0, 2–7 and 28 give G1. Codes 1, 8–14 and 29 give G2. Codes 16–27, 30 and 31 give G3. Code 15 gives G4.
- R6: On the edge that first samples `rcv_mode_i`=1, the recovery-select bit and the override-rule code are frozen. With the frozen select at 1: `mode_o`=2'b11, `n_o`/`m_o` follow `rcv_n_i`/`rcv_m_i`, and `code_o` is the frozen code. With the frozen select at 0: `mode_o`=2'b10, `code_o` is the strap copy, and `n_o`=`m_o`=0.
- R7: During recovery, changes to `sw_code_i`, `override_i`, `prog_en_i`, `norm_n_i`, `norm_m_i` and `rcv_sel_i` leave all outputs unchanged. Changes to the recovery pair are followed while in mode 2'b11.
- R8: The first edge that samples `rcv_mode_i`=0 after recovery returns the outputs to the rules of R3/R4, using the current inputs.
- R9: `load_o` is 1 for exactly the one cycle after an edge that changed `code_o`, `n_o`, `m_o` or `mode_o`, and 0 otherwise. Entry to or exit from recovery always changes `mode_o`.
- R10: Every output reflects the inputs sampled at the single preceding rising edge. The latency is one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | CODE_W | Strap pins, captured once after power-up |
| sw_code_i | input | CODE_W | Software ratio select code |
| prog_en_i | input | 1 | Programmable N/M mode enable |
| override_i | input | 1 | 1: software code sets the ratio; 0: straps do |
| norm_n_i | input | N_W | Programmable N value |
| norm_m_i | input | M_W | Programmable M value |
| rcv_n_i | input | N_W | Recovery N value |
| rcv_m_i | input | M_W | Recovery M value |
| rcv_sel_i | input | 1 | Recovery source: 1 recovery pair, 0 straps |
| rcv_mode_i | input | 1 | Recovery mode flag from the watchdog |
| code_o | output | CODE_W | Active ratio code |
| gear_o | output | 2 | Gear constant index (0..3 = G1..G4) |
| n_o | output | N_W | Active N (0 when not programmable) |
| m_o | output | M_W | Active M (0 when not programmable) |
| mode_o | output | 2 | 00 table, 01 programmable, 10 recovery-strap, 11 recovery-N/M |
| load_o | output | 1 | One-cycle pulse when the setting changed |

## Verification
Every selection output and the load pulse are due one rising edge after the inputs they depend on are sampled. The one exception is the strap copy: it is taken on the STRAP_DELAY-th edge after reset and shows on `code_o` one edge later. The driver changes inputs just after a falling edge and computes the expected result for the next rising edge. It queues that result tagged with the cycle number. The monitor compares at the following falling edge, exactly one edge after the stimulus, so a result that arrives a cycle early or late is caught as a mismatch.

// File: rtl/clk_src_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock synthesizer setting selector.
// Holds the gear index and mode encodings, plus the code-to-gear rule.
// Assumes ratio codes are at most 5 bits; codes above 31 fall to G3.
package clk_src_pkg;

    localparam int unsigned GEAR_W = 2;
    localparam int unsigned MODE_W = 2;

    typedef enum logic [GEAR_W-1:0] {
        GEAR_1 = 2'd0,
        GEAR_2 = 2'd1,
        GEAR_3 = 2'd2,
        GEAR_4 = 2'd3
    } gear_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_TABLE     = 2'b00,
        MODE_PROG      = 2'b01,
        MODE_RCV_STRAP = 2'b10,
        MODE_RCV_NM    = 2'b11
    } mode_e;

    // Gear constant picked by a ratio code
    function automatic gear_e gear_of(input int unsigned code);
        if (code == 15)
            return GEAR_4;
        else if (code == 0 || (code >= 2 && code <= 7) || code == 28)
            return GEAR_1;
        else if (code == 1 || (code >= 8 && code <= 14) || code == 29)
            return GEAR_2;
        else
            return GEAR_3;
    endfunction

endpackage

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
// Power-up strap sampler.
// Counts DELAY clock edges after reset release, copies the strap pins once,
// then holds that copy until the next reset. Before capture the copy reads 0.
// Assumes DELAY >= 1; the count range is a plain counter limit.
module strap_capture #(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned DELAY  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] strap_i,
    output logic [CODE_W-1:0] strap_o
);
    localparam int unsigned CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic [CODE_W-1:0] strap_q;

    // Delay counter and one-shot strap copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            done_q  <= 1'b0;
            strap_q <= '0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                strap_q <= strap_i;
                done_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign strap_o = strap_q;

    // R2
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (done_q && $stable(strap_q)));

    // R2
    strap_zero_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (strap_q == '0));

endmodule

// File: rtl/gear_lookup.sv
`timescale 1ns/1ps
// Ratio code to gear constant index.
// Builds one entry per possible code from the package rule at elaboration,
// then indexes it with the live code. Purely combinational.
module gear_lookup
    import clk_src_pkg::*;
#(
    parameter int unsigned CODE_W = 5
) (
    input  logic [CODE_W-1:0] code_i,
    output gear_e             gear_o
);
    localparam int unsigned ENTRIES = 1 << CODE_W;

    gear_e lut [ENTRIES];

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
        assign lut[gi] = gear_of(gi);
    end

    assign gear_o = lut[code_i];

endmodule

// File: rtl/recovery_hold.sv
`timescale 1ns/1ps
// Recovery freeze stage.
// Tracks the recovery flag and, while not in recovery, keeps copying the
// override-rule code and the recovery-select bit. Once recovery is entered the
// copies stop, so later software writes cannot move the selection.
// The effective values pass the live ones through on the entry edge itself.
module recovery_hold #(
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rcv_mode_i,
    input  logic [CODE_W-1:0] live_code_i,
    input  logic              rcv_sel_i,
    output logic [CODE_W-1:0] code_eff_o,
    output logic              sel_eff_o
);
    logic              rcv_q;
    logic [CODE_W-1:0] frz_code_q;
    logic              frz_sel_q;

    // Recovery state and frozen copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcv_q      <= 1'b0;
            frz_code_q <= '0;
            frz_sel_q  <= 1'b0;
        end else begin
            rcv_q <= rcv_mode_i;
            if (!rcv_q) begin
                frz_code_q <= live_code_i;
                frz_sel_q  <= rcv_sel_i;
            end
        end
    end

    // Frozen values in recovery, live values otherwise
    always_comb begin
        code_eff_o = rcv_q ? frz_code_q : live_code_i;
        sel_eff_o  = rcv_q ? frz_sel_q  : rcv_sel_i;
    end

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_q |=> ($stable(frz_code_q) && $stable(frz_sel_q)));

endmodule

// File: rtl/source_mux.sv
`timescale 1ns/1ps
// Setting source resolution.
// Picks the ratio code, N, M and mode from the live configuration, following
// the recovery, programmable and table rules in that priority. Combinational.
// Assumes the caller supplies the frozen-or-live code and select for recovery.
module source_mux
    import clk_src_pkg::*;
#(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned N_W    = 8,
    parameter int unsigned M_W    = 7
) (
    input  logic [CODE_W-1:0] live_code_i,
    input  logic [CODE_W-1:0] strap_code_i,
    input  logic              prog_en_i,
    input  logic [N_W-1:0]    norm_n_i,
    input  logic [M_W-1:0]    norm_m_i,
    input  logic [N_W-1:0]    rcv_n_i,
    input  logic [M_W-1:0]    rcv_m_i,
    input  logic              rcv_mode_i,
    input  logic [CODE_W-1:0] code_eff_i,
    input  logic              sel_eff_i,
    output logic [CODE_W-1:0] code_o,
    output logic [N_W-1:0]    n_o,
    output logic [M_W-1:0]    m_o,
    output mode_e             mode_o
);
    // Priority selection of the effective setting
    always_comb begin
        code_o = live_code_i;
        n_o    = '0;
        m_o    = '0;
        mode_o = MODE_TABLE;
        if (rcv_mode_i) begin
            if (sel_eff_i) begin
                code_o = code_eff_i;
                n_o    = rcv_n_i;
                m_o    = rcv_m_i;
                mode_o = MODE_RCV_NM;
            end else begin
                code_o = strap_code_i;
                mode_o = MODE_RCV_STRAP;
            end
        end else if (prog_en_i) begin
            n_o    = norm_n_i;
            m_o    = norm_m_i;
            mode_o = MODE_PROG;
        end
    end

endmodule

// File: rtl/clk_src_select.sv
`timescale 1ns/1ps
// Clock synthesizer setting selector, top level.
// Combines the strap copy, software code, programmable and recovery N/M pairs
// into one registered setting, with a gear index and a one-cycle load pulse
// whenever code, N, M or mode moves. Inputs are register levels, assumed
// synchronous to clk. STRAP_DELAY is the power-up strap wait in clocks.
module clk_src_select
    import clk_src_pkg::*;
#(
    parameter int unsigned CODE_W      = 5,
    parameter int unsigned N_W         = 8,
    parameter int unsigned M_W         = 7,
    parameter int unsigned STRAP_DELAY = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] strap_i,
    input  logic [CODE_W-1:0] sw_code_i,
    input  logic              prog_en_i,
    input  logic              override_i,
    input  logic [N_W-1:0]    norm_n_i,
    input  logic [M_W-1:0]    norm_m_i,
    input  logic [N_W-1:0]    rcv_n_i,
    input  logic [M_W-1:0]    rcv_m_i,
    input  logic              rcv_sel_i,
    input  logic              rcv_mode_i,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        gear_o,
    output logic [N_W-1:0]    n_o,
    output logic [M_W-1:0]    m_o,
    output logic [1:0]        mode_o,
    output logic              load_o
);
    logic [CODE_W-1:0] strap_code;
    logic [CODE_W-1:0] live_code;
    logic [CODE_W-1:0] code_eff;
    logic              sel_eff;
    logic [CODE_W-1:0] code_nx;
    logic [N_W-1:0]    n_nx;
    logic [M_W-1:0]    m_nx;
    mode_e             mode_nx;
    gear_e             gear_nx;

    logic [CODE_W-1:0] code_q;
    logic [N_W-1:0]    n_q;
    logic [M_W-1:0]    m_q;
    mode_e             mode_q;
    gear_e             gear_q;
    logic              load_q;

    strap_capture #(
        .CODE_W (CODE_W),
        .DELAY  (STRAP_DELAY)
    ) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .strap_o (strap_code)
    );

    // Override rule: software code or strap copy
    assign live_code = override_i ? sw_code_i : strap_code;

    recovery_hold #(
        .CODE_W (CODE_W)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .rcv_mode_i  (rcv_mode_i),
        .live_code_i (live_code),
        .rcv_sel_i   (rcv_sel_i),
        .code_eff_o  (code_eff),
        .sel_eff_o   (sel_eff)
    );

    source_mux #(
        .CODE_W (CODE_W),
        .N_W    (N_W),
        .M_W    (M_W)
    ) u_mux (
        .live_code_i  (live_code),
        .strap_code_i (strap_code),
        .prog_en_i    (prog_en_i),
        .norm_n_i     (norm_n_i),
        .norm_m_i     (norm_m_i),
        .rcv_n_i      (rcv_n_i),
        .rcv_m_i      (rcv_m_i),
        .rcv_mode_i   (rcv_mode_i),
        .code_eff_i   (code_eff),
        .sel_eff_i    (sel_eff),
        .code_o       (code_nx),
        .n_o          (n_nx),
        .m_o          (m_nx),
        .mode_o       (mode_nx)
    );

    gear_lookup #(
        .CODE_W (CODE_W)
    ) u_gear (
        .code_i (code_nx),
        .gear_o (gear_nx)
    );

    // Output registers and change-detect load pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            n_q    <= '0;
            m_q    <= '0;
            mode_q <= MODE_TABLE;
            gear_q <= GEAR_1;
            load_q <= 1'b0;
        end else begin
            code_q <= code_nx;
            n_q    <= n_nx;
            m_q    <= m_nx;
            mode_q <= mode_nx;
            gear_q <= gear_nx;
            load_q <= (code_nx != code_q) || (n_nx != n_q) ||
                      (m_nx != m_q) || (mode_nx != mode_q);
        end
    end

    assign code_o = code_q;
    assign gear_o = gear_q;
    assign n_o    = n_q;
    assign m_o    = m_q;
    assign mode_o = mode_q;
    assign load_o = load_q;

    // R3
    table_nm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TABLE || mode_q == MODE_RCV_STRAP) |-> (n_q == '0 && m_q == '0));

    // R9
    load_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q) || n_q != $past(n_q) ||
         m_q != $past(m_q) || mode_q != $past(mode_q)) |-> load_q);

    // R9
    load_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> (code_q != $past(code_q) || n_q != $past(n_q) ||
                    m_q != $past(m_q) || mode_q != $past(mode_q)));

    // R5
    gear_top_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gear_q == GEAR_4) == (code_q == CODE_W'(15)));

    // R7
    rcv_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RCV_NM && $past(mode_q) == MODE_RCV_NM) |-> $stable(code_q));

endmodule

// File: tb/test_clk_src_select.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected result for each edge and
// the monitor compares it one edge later, at the falling edge.
module test_clk_src_select;

    localparam int DLY = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] strap, sw;
    logic       prog, ovr, rsel, rmode;
    logic [7:0] nn, rn;
    logic [6:0] nm, rm;

    logic [4:0] code_o;
    logic [1:0] gear_o;
    logic [7:0] n_o;
    logic [6:0] m_o;
    logic [1:0] mode_o;
    logic       load_o;

    always #2 clk = ~clk;

    clk_src_select #(
        .CODE_W      (5),
        .N_W         (8),
        .M_W         (7),
        .STRAP_DELAY (DLY)
    ) i_clk_src_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap),
        .sw_code_i  (sw),
        .prog_en_i  (prog),
        .override_i (ovr),
        .norm_n_i   (nn),
        .norm_m_i   (nm),
        .rcv_n_i    (rn),
        .rcv_m_i    (rm),
        .rcv_sel_i  (rsel),
        .rcv_mode_i (rmode),
        .code_o     (code_o),
        .gear_o     (gear_o),
        .n_o        (n_o),
        .m_o        (m_o),
        .mode_o     (mode_o),
        .load_o     (load_o)
    );

    typedef struct {
        int         due;
        string      tag;
        logic [4:0] code;
        logic [1:0] gear;
        logic [7:0] n;
        logic [6:0] m;
        logic [1:0] mode;
        logic       load;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    // Reference state
    logic [4:0] r_strap, r_fcode;
    int         r_cnt;
    bit         r_done, r_rcv, r_fsel;
    logic [4:0] e_code;
    logic [1:0] e_gear, e_mode;
    logic [7:0] e_n;
    logic [6:0] e_m;
    logic       e_load;

    always @(posedge clk) cyc <= cyc + 1;

    // Gear map from R5
    function automatic logic [1:0] gear_ref(input logic [4:0] c);
        int v = int'(c);
        if (v == 15) return 2'd3;
        if (v == 0 || v == 28 || (v >= 2 && v <= 7)) return 2'd0;
        if (v == 1 || v == 29 || (v >= 8 && v <= 14)) return 2'd1;
        return 2'd2;
    endfunction

    // Expected outputs after the coming edge, from the requirements
    task automatic ref_step();
        logic [4:0] live, c;
        logic [7:0] n;
        logic [6:0] m;
        logic [1:0] md;
        logic [4:0] fc;
        bit         fs;
        if (!rst_n) begin
            r_strap = '0; r_cnt = 0; r_done = 0; r_rcv = 0; r_fcode = '0; r_fsel = 0;
            e_code = '0; e_gear = '0; e_n = '0; e_m = '0; e_mode = '0; e_load = 1'b0;
            return;
        end
        live = ovr ? sw : r_strap;
        fc   = r_rcv ? r_fcode : live;
        fs   = r_rcv ? r_fsel : rsel;
        n = '0; m = '0;
        if (rmode && fs) begin
            c = fc; n = rn; m = rm; md = 2'b11;
        end else if (rmode) begin
            c = r_strap; md = 2'b10;
        end else if (prog) begin
            c = live; n = nn; m = nm; md = 2'b01;
        end else begin
            c = live; md = 2'b00;
        end
        e_load = (c != e_code) || (n != e_n) || (m != e_m) || (md != e_mode);
        e_code = c; e_n = n; e_m = m; e_mode = md; e_gear = gear_ref(c);
        if (rmode && !r_rcv) begin
            r_fcode = live; r_fsel = rsel;
        end
        r_rcv = rmode;
        if (!r_done) begin
            r_cnt++;
            if (r_cnt == DLY) begin
                r_strap = strap; r_done = 1;
            end
        end
    endtask

    // Driver: queue expectation for the next edge, then advance one cycle
    task automatic tick(input string tag);
        exp_t e;
        ref_step();
        e.due = cyc + 1; e.tag = tag;
        e.code = e_code; e.gear = e_gear; e.n = e_n; e.m = e_m;
        e.mode = e_mode; e.load = e_load;
        sb_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare outputs one edge after each stimulus
    always @(negedge clk) begin : monitor
        exp_t e;
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            e = sb_q.pop_front();
            checks++;
            if ({code_o, gear_o, n_o, m_o, mode_o, load_o} !==
                {e.code, e.gear, e.n, e.m, e.mode, e.load}) begin
                errors++;
                $display("FAIL %s cyc %0d: actual code=%0d gear=%0d n=%0d m=%0d mode=%0d load=%0b expected code=%0d gear=%0d n=%0d m=%0d mode=%0d load=%0b",
                         e.tag, cyc, code_o, gear_o, n_o, m_o, mode_o, load_o,
                         e.code, e.gear, e.n, e.m, e.mode, e.load);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog: actual=hung expected=completed run");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        rst_n = 1'b0; strap = 5'd9; sw = '0; prog = 0; ovr = 0;
        nn = '0; nm = '0; rn = '0; rm = '0; rsel = 0; rmode = 0;
        @(negedge clk);
        repeat (3) tick("R1");
        rst_n = 1'b1;
        // strap capture on the DLY-th edge, visible one edge later
        repeat (DLY + 2) tick("R2");
        strap = 5'd21;
        repeat (2) tick("R2");
        // table mode, override rule
        ovr = 1; sw = 5'd17; tick("R3");
        sw = 5'd15; tick("R10");
        tick("R9");
        nn = 8'd44; nm = 7'd3; tick("R3");
        ovr = 0; tick("R3");
        // programmable mode
        prog = 1; nn = 8'd77; nm = 7'd48; tick("R4");
        nm = 7'd49; tick("R4");
        ovr = 1; sw = 5'd28; tick("R4");
        tick("R9");
        // gear map sweep
        prog = 0;
        for (int i = 0; i < 32; i++) begin
            sw = i[4:0];
            tick("R5");
        end
        // recovery with recovery pair
        prog = 1; sw = 5'd1; nn = 8'd20; nm = 7'd30; rn = 8'd100; rm = 7'd50; rsel = 1;
        tick("R4");
        rmode = 1; tick("R6");
        tick("R6");
        sw = 5'd30; tick("R7");
        ovr = 0; tick("R7");
        prog = 0; nn = 8'd5; tick("R7");
        rsel = 0; tick("R7");
        rn = 8'd101; tick("R7");
        rm = 7'd51; tick("R7");
        // exit
        rmode = 0; tick("R8");
        tick("R8");
        // recovery from straps
        ovr = 1; sw = 5'd3; tick("R8");
        rmode = 1; tick("R6");
        sw = 5'd4; ovr = 0; tick("R7");
        rmode = 0; tick("R8");
        // reset in mid-run
        rst_n = 1'b0; repeat (2) tick("R1");
        rst_n = 1'b1; repeat (DLY + 2) tick("R2");
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R10 pending results: actual=%0d expected=0", sb_q.size());
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule